// File: doc/BRIEF.md
# Peripheral Interrupt Flag Controller

This block keeps the interrupt state of a byte-wide peripheral whose sixteen registers sit in an 8 KB address window. Pulses from a shift engine (transfer done, data edge, clock edge) and from two timers set bits in a flag register. Software masks these flags through an enable register and drives them back to zero by writing ones to the flag register. A single level interrupt line tells the processor that something needing attention is pending.

The block turns the bus address into a 4-bit register index and exports that index for the neighbouring timer and shift blocks. It answers reads of the flag and enable registers itself. It carries out the clear-on-access side effects of other registers: it clears the shift flags on its own when the shift data register is read, and it takes a clear mask from the timer blocks when their counter accesses clear a timer flag. An event always beats a clear that lands in the same cycle, so no event is lost. The interrupt output is a register, which keeps the path to the processor short.

Top module: `irqf_ctrl`

## Requirements
- R1: `reg_index` equals address bits 12:9. The flag register is index 13, the enable register is index 14 and the shift data register is index 10. A read of any other index returns 0x00 on `rd_data`.
- R2: After reset the flag register reads 0x00, the enable register reads 0x80 and `irq` is 0.
- R3: An event pulse sets its flag bit on the next clock edge: shift done sets bit 2, shift data sets bit 3, shift clock sets bit 4, timer 2 sets bit 5 and timer 1 sets bit 6. Bits 1:0 never set.
- R4: A write to the enable register with bit 7 = 1 ORs data bits 6:0 into the enable mask.
- R5: A write to the enable register with bit 7 = 0 clears each mask bit that is written as 1 and leaves the other bits unchanged.
- R6: A read of the enable register returns the mask in bits 6:0, with bit 7 always 1.
- R7: A read of the flag register returns the flags in bits 6:0. Bit 7 is 1 exactly when some flag bit in 6:0 is also enabled, including bits that do not drive `irq`.
- R8: A write to the flag register clears each flag bit that is written as 1 and leaves the other bits unchanged.
- R9: `irq` follows only flag AND enable in bits 2, 5 and 6. Enabled shift-data or shift-clock flags alone leave it at 0.
- R10: A read of the shift data register (index 10) clears flag bits 2, 3 and 4 and leaves bits 5 and 6 unchanged.
- R11: Each bit set in `clr_req[6:0]` for one cycle clears the matching flag bit.
- R12: When an event and any clear (flag write, shift data read or `clr_req`) hit the same bit in the same cycle, the flag ends up set.
- R13: `irq` is registered. It changes on the clock edge after the edge that changes a flag or an enable bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 13 | Byte address inside the 8 KB window |
| bus_wr | input | 1 | Write strobe, one cycle per access |
| bus_rd | input | 1 | Read strobe, one cycle per access |
| bus_wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data for the flag and enable registers, 0x00 for other indices |
| reg_index | output | 4 | Decoded register index for neighbouring blocks |
| ev_shift_done | input | 1 | Shift engine transfer-complete pulse |
| ev_shift_data | input | 1 | Shift engine data pulse |
| ev_shift_clk | input | 1 | Shift engine clock pulse |
| ev_tmr2 | input | 1 | Timer 2 expiry pulse |
| ev_tmr1 | input | 1 | Timer 1 expiry pulse |
| clr_req | input | 7 | Flag clear mask requested by other register accesses |
| irq | output | 1 | Level interrupt to the processor |

## Verification
The assertions check four things on every cycle: that an event always leaves its flag set one edge later, even when a clear hits the same bit; that an enable set write or clear write changes the mask as the selector bit says; that a flag write with no competing event leaves the written bits clear; and that `irq` matches the previous cycle's masked pending bits. Some behaviour can only be shown by the bench scenarios, because it depends on what software sees across a sequence of accesses. This covers the read formats, with bit 7 forced on enable reads and computed as a summary on flag reads. It also covers the exact bit each event sets, the group of flags that a shift data read clears, the way enabled shift-data and shift-clock flags are kept off the interrupt line, and the one-cycle lag of `irq`.

// File: rtl/irqf_pkg.sv
// Package: shared constants for the interrupt flag controller.
// Holds the flag bit positions, the register indices that the neighbouring
// blocks also decode, and the masks derived from them.
package irqf_pkg;

    localparam int FLAG_W = 7;           // flag/enable bits 6:0, bit 7 synthesized
    localparam int IDX_W  = 4;           // sixteen registers

    // flag bit positions
    localparam int B_SH_DONE = 2;
    localparam int B_SH_DATA = 3;
    localparam int B_SH_CLK  = 4;
    localparam int B_TMR2    = 5;
    localparam int B_TMR1    = 6;

    // register indices decoded here
    localparam logic [IDX_W-1:0] IDX_SHIFT  = 4'd10;
    localparam logic [IDX_W-1:0] IDX_FLAG   = 4'd13;
    localparam logic [IDX_W-1:0] IDX_ENABLE = 4'd14;

    // bits that may drive the interrupt line
    localparam logic [FLAG_W-1:0] IRQ_MASK =
        FLAG_W'((1 << B_SH_DONE) | (1 << B_TMR2) | (1 << B_TMR1));

    // bits cleared by a shift data read
    localparam logic [FLAG_W-1:0] SHIFT_CLR_MASK =
        FLAG_W'((1 << B_SH_DONE) | (1 << B_SH_DATA) | (1 << B_SH_CLK));

endpackage

// File: rtl/irqf_decode.sv
// Module: irqf_decode
// Turns a bus address and strobes into a register index and per-register
// access pulses. Assumes strobes last one cycle per access and the index
// field sits at IDX_LSB upward in the address.
module irqf_decode
    import irqf_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int IDX_LSB = 9
) (
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    output logic [IDX_W-1:0]  reg_index,
    output logic              wr_flag,
    output logic              wr_enable,
    output logic              rd_flag,
    output logic              rd_enable,
    output logic              rd_shift
);

    localparam logic [ADDR_W-1:0] SHIFTED_MAX = ADDR_W'((1 << IDX_W) - 1);

    logic [ADDR_W-1:0] addr_shifted;

    // extract the index field from the address
    always_comb begin
        addr_shifted = (bus_addr >> IDX_LSB) & SHIFTED_MAX;
        reg_index    = addr_shifted[IDX_W-1:0];
    end

    // qualify strobes with the decoded index
    always_comb begin
        wr_flag   = bus_wr && (reg_index == IDX_FLAG);
        wr_enable = bus_wr && (reg_index == IDX_ENABLE);
        rd_flag   = bus_rd && (reg_index == IDX_FLAG);
        rd_enable = bus_rd && (reg_index == IDX_ENABLE);
        rd_shift  = bus_rd && (reg_index == IDX_SHIFT);
    end

endmodule

// File: rtl/irqf_flag_bank.sv
// Module: irqf_flag_bank
// Holds the pending flags. Events set bits; flag writes, shift data reads
// and external requests clear bits. A set beats a clear on the same bit in
// the same cycle. Assumes event inputs are single-cycle pulses.
module irqf_flag_bank
    import irqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] set_ev,
    input  logic              wr_flag,
    input  logic [FLAG_W-1:0] wdata,
    input  logic              rd_shift,
    input  logic [FLAG_W-1:0] ext_clr,
    output logic [FLAG_W-1:0] flags
);

    logic [FLAG_W-1:0] clr_all;
    logic [FLAG_W-1:0] flags_nxt;

    // merge every clear source into one mask
    always_comb begin
        clr_all = ext_clr;
        if (wr_flag)  clr_all = clr_all | wdata;
        if (rd_shift) clr_all = clr_all | SHIFT_CLR_MASK;
    end

    // clear first, then set, so events are never lost
    always_comb begin
        flags_nxt = (flags & ~clr_all) | set_ev;
    end

    // flag register with synchronous reset
    always_ff @(posedge clk) begin
        if (!rst_n) flags <= '0;
        else        flags <= flags_nxt;
    end

    // an event always leaves its flag set, whatever clears compete
    genvar gi;
    generate
        for (gi = 0; gi < FLAG_W; gi++) begin : g_ev_chk
            assert_event_kept_R12: assert property (@(posedge clk) disable iff (!rst_n)
                set_ev[gi] |=> flags[gi]);
        end
    endgenerate

    // a flag write with no competing source clears the written bits
    assert_flag_write_clears_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_flag && set_ev == '0) |=> ((flags & $past(wdata)) == '0));

endmodule

// File: rtl/irqf_enable_mask.sv
// Module: irqf_enable_mask
// Holds the enable mask. A write with the selector bit high ORs the data in;
// with the selector low it clears the bits written as one.
module irqf_enable_mask
    import irqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_enable,
    input  logic              set_sel,
    input  logic [FLAG_W-1:0] wdata,
    output logic [FLAG_W-1:0] enables
);

    // mask update per selector
    always_ff @(posedge clk) begin
        if (!rst_n)         enables <= '0;
        else if (wr_enable) enables <= set_sel ? (enables | wdata) : (enables & ~wdata);
    end

    assert_enable_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && set_sel) |=> ((enables & $past(wdata)) == $past(wdata)));

    assert_enable_clear_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_enable && !set_sel) |=> ((enables & $past(wdata)) == '0));

    assert_enable_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_enable |=> $stable(enables));

endmodule

// File: rtl/irqf_irq_out.sv
// Module: irqf_irq_out
// Registers the interrupt line from the masked pending bits of the
// interrupt-capable flags. Adds one cycle of latency by design.
module irqf_irq_out
    import irqf_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [FLAG_W-1:0] flags,
    input  logic [FLAG_W-1:0] enables,
    output logic              irq
);

    // register the line from the current flag and enable state
    always_ff @(posedge clk) begin
        if (!rst_n) irq <= 1'b0;
        else        irq <= |(flags & enables & IRQ_MASK);
    end

    assert_irq_lag_R13: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> (irq == $past(|(flags & enables & IRQ_MASK))));

    assert_irq_shift_only_R9: assert property (@(posedge clk) disable iff (!rst_n)
        ((flags & IRQ_MASK) == '0) |=> !irq);

endmodule

// File: rtl/irqf_ctrl.sv
// Module: irqf_ctrl (top)
// Interrupt flag and enable bookkeeping for a sixteen-register byte-wide
// peripheral. Decodes the register index, serves flag and enable reads,
// applies clear-on-access requests and drives one registered interrupt.
// Assumes one-cycle bus strobes and one-cycle event pulses.
module irqf_ctrl
    import irqf_pkg::*;
#(
    parameter int ADDR_W  = 13,
    parameter int IDX_LSB = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        rd_data,
    output logic [IDX_W-1:0]  reg_index,
    input  logic              ev_shift_done,
    input  logic              ev_shift_data,
    input  logic              ev_shift_clk,
    input  logic              ev_tmr2,
    input  logic              ev_tmr1,
    input  logic [FLAG_W-1:0] clr_req,
    output logic              irq
);

    logic              wr_flag, wr_enable, rd_flag, rd_enable, rd_shift;
    logic [FLAG_W-1:0] set_ev;
    logic [FLAG_W-1:0] flags;
    logic [FLAG_W-1:0] enables;

    irqf_decode #(.ADDR_W(ADDR_W), .IDX_LSB(IDX_LSB)) u_decode (
        .bus_addr  (bus_addr),
        .bus_wr    (bus_wr),
        .bus_rd    (bus_rd),
        .reg_index (reg_index),
        .wr_flag   (wr_flag),
        .wr_enable (wr_enable),
        .rd_flag   (rd_flag),
        .rd_enable (rd_enable),
        .rd_shift  (rd_shift)
    );

    // place each event pulse at its flag position
    always_comb begin
        set_ev            = '0;
        set_ev[B_SH_DONE] = ev_shift_done;
        set_ev[B_SH_DATA] = ev_shift_data;
        set_ev[B_SH_CLK]  = ev_shift_clk;
        set_ev[B_TMR2]    = ev_tmr2;
        set_ev[B_TMR1]    = ev_tmr1;
    end

    irqf_flag_bank u_flags (
        .clk      (clk),
        .rst_n    (rst_n),
        .set_ev   (set_ev),
        .wr_flag  (wr_flag),
        .wdata    (bus_wdata[FLAG_W-1:0]),
        .rd_shift (rd_shift),
        .ext_clr  (clr_req),
        .flags    (flags)
    );

    irqf_enable_mask u_enable (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_enable (wr_enable),
        .set_sel   (bus_wdata[7]),
        .wdata     (bus_wdata[FLAG_W-1:0]),
        .enables   (enables)
    );

    irqf_irq_out u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .flags   (flags),
        .enables (enables),
        .irq     (irq)
    );

    // read data for the two registers owned here
    always_comb begin
        if (rd_flag)        rd_data = {|(flags & enables), flags};
        else if (rd_enable) rd_data = {1'b1, enables};
        else                rd_data = 8'h00;
    end

    assert_read_onehot_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_flag, rd_enable, rd_shift}));

    assert_shift_read_clears_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_shift && !ev_shift_done && !ev_shift_data && !ev_shift_clk)
            |=> ((flags & SHIFT_CLR_MASK) == '0));

endmodule

// File: tb/irqf_ctrl_tb_top.sv
module irqf_ctrl_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [12:0] bus_addr = '0;
    logic        bus_wr = 1'b0;
    logic        bus_rd = 1'b0;
    logic [7:0]  bus_wdata = '0;
    logic [7:0]  rd_data;
    logic [3:0]  reg_index;
    logic        ev_shift_done = 1'b0, ev_shift_data = 1'b0, ev_shift_clk = 1'b0;
    logic        ev_tmr2 = 1'b0, ev_tmr1 = 1'b0;
    logic [6:0]  clr_req = '0;
    logic        irq;

    int n_checks = 0;
    int n_bad = 0;
    bit done = 1'b0;

    localparam logic [3:0] I_SHIFT = 4'd10, I_FLAG = 4'd13, I_EN = 4'd14;

    always #4 clk = ~clk;

    irqf_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .rd_data(rd_data),
        .reg_index(reg_index), .ev_shift_done(ev_shift_done),
        .ev_shift_data(ev_shift_data), .ev_shift_clk(ev_shift_clk),
        .ev_tmr2(ev_tmr2), .ev_tmr1(ev_tmr1), .clr_req(clr_req), .irq(irq)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic wr_reg(input logic [3:0] idx, input logic [7:0] d);
        @(negedge clk);
        bus_addr = {idx, 9'h000}; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_reg(input logic [3:0] idx, output logic [7:0] d);
        @(negedge clk);
        bus_addr = {idx, 9'h000}; bus_rd = 1'b1;
        #1 d = rd_data;
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    // one-cycle pulse on the events selected by flag-bit mask m
    task automatic pulse(input logic [6:0] m);
        @(negedge clk);
        ev_shift_done = m[2]; ev_shift_data = m[3]; ev_shift_clk = m[4];
        ev_tmr2 = m[5]; ev_tmr1 = m[6];
        @(negedge clk);
        {ev_shift_done, ev_shift_data, ev_shift_clk, ev_tmr2, ev_tmr1} = '0;
    endtask

    task automatic clean();
        wr_reg(I_EN, 8'h7F);
        wr_reg(I_FLAG, 8'h7F);
    endtask

    task automatic t_reset();
        logic [7:0] d;
        rd_reg(I_FLAG, d); check("R2 flag reset", d, 8'h00);
        rd_reg(I_EN, d);   check("R2 enable reset", d, 8'h80);
        check("R2 irq reset", {7'b0, irq}, 8'h00);
    endtask

    task automatic t_index();
        logic [7:0] d;
        @(negedge clk); bus_addr = 13'h1FFF; #1;
        check("R1 index high", {4'b0, reg_index}, 8'h0F);
        bus_addr = 13'h0BFF; #1;
        check("R1 index 5", {4'b0, reg_index}, 8'h05);
        bus_addr = 13'h1A00; #1;
        check("R1 index 13", {4'b0, reg_index}, 8'h0D);
        wr_reg(I_EN, 8'hFF);
        pulse(7'h7C);
        rd_reg(4'd3, d); check("R1 other index reads zero", d, 8'h00);
        clean();
    endtask

    task automatic t_events();
        logic [7:0] d;
        for (int b = 2; b <= 6; b++) begin
            pulse(7'(1 << b));
            rd_reg(I_FLAG, d); check("R3 event bit", d, 8'(1 << b));
            wr_reg(I_FLAG, 8'(1 << b));
            rd_reg(I_FLAG, d); check("R8 write clears bit", d, 8'h00);
        end
        pulse(7'h60);
        wr_reg(I_FLAG, 8'h20);
        rd_reg(I_FLAG, d); check("R8 unwritten bit kept", d, 8'h40);
        clean();
    endtask

    task automatic t_enable();
        logic [7:0] d;
        wr_reg(I_EN, 8'hA4);
        rd_reg(I_EN, d); check("R4 set write", d, 8'hA4);
        wr_reg(I_EN, 8'hC0);
        rd_reg(I_EN, d); check("R4 set ORs", d, 8'hE4);
        wr_reg(I_EN, 8'h04);
        rd_reg(I_EN, d); check("R5 clear write", d, 8'hE0);
        wr_reg(I_EN, 8'h00);
        rd_reg(I_EN, d); check("R6 bit7 always set", d, 8'hE0);
        clean();
    endtask

    task automatic t_summary();
        logic [7:0] d;
        pulse(7'h18);
        rd_reg(I_FLAG, d); check("R7 no enable no summary", d, 8'h18);
        wr_reg(I_EN, 8'h98);
        rd_reg(I_FLAG, d); check("R7 summary on shift data", d, 8'h98);
        @(negedge clk);
        check("R9 shift data/clock no irq", {7'b0, irq}, 8'h00);
        clean();
    endtask

    task automatic t_irq_timing();
        wr_reg(I_EN, 8'hC0);
        pulse(7'h40);
        check("R13 irq lags flag", {7'b0, irq}, 8'h00);
        @(negedge clk);
        check("R9 irq on timer1", {7'b0, irq}, 8'h01);
        wr_reg(I_FLAG, 8'h40);
        check("R13 irq lags clear", {7'b0, irq}, 8'h01);
        @(negedge clk);
        check("R13 irq drops", {7'b0, irq}, 8'h00);
        wr_reg(I_EN, 8'hA4);
        pulse(7'h04);
        @(negedge clk);
        check("R9 irq on shift done", {7'b0, irq}, 8'h01);
        wr_reg(I_EN, 8'h04);
        @(negedge clk);
        check("R13 irq drops after disable", {7'b0, irq}, 8'h00);
        clean();
    endtask

    task automatic t_shift_read();
        logic [7:0] d;
        pulse(7'h7C);
        rd_reg(I_SHIFT, d);
        rd_reg(I_FLAG, d); check("R10 shift read clears shift flags", d, 8'h60);
        clean();
    endtask

    task automatic t_ext_clr();
        logic [7:0] d;
        pulse(7'h60);
        @(negedge clk); clr_req = 7'h40;
        @(negedge clk); clr_req = '0;
        rd_reg(I_FLAG, d); check("R11 external clear", d, 8'h20);
        clean();
    endtask

    task automatic t_set_wins();
        logic [7:0] d;
        pulse(7'h40);
        @(negedge clk);
        bus_addr = {I_FLAG, 9'h000}; bus_wdata = 8'h40; bus_wr = 1'b1; ev_tmr1 = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0; ev_tmr1 = 1'b0;
        rd_reg(I_FLAG, d); check("R12 set beats flag write", d, 8'h40);
        @(negedge clk);
        bus_addr = {I_SHIFT, 9'h000}; bus_rd = 1'b1; ev_shift_done = 1'b1;
        @(negedge clk);
        bus_rd = 1'b0; ev_shift_done = 1'b0;
        rd_reg(I_FLAG, d); check("R12 set beats shift read", d, 8'h44);
        @(negedge clk); clr_req = 7'h20; ev_tmr2 = 1'b1;
        @(negedge clk); clr_req = '0; ev_tmr2 = 1'b0;
        rd_reg(I_FLAG, d); check("R12 set beats clear request", d, 8'h64);
        clean();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_index();
        t_events();
        t_enable();
        t_summary();
        t_irq_timing();
        t_shift_read();
        t_ext_clr();
        t_set_wins();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", n_checks, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_bad++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", n_checks, n_bad);
            $finish;
        end
    end

endmodule